// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 device from power-on to its operational state by walking a fixed bring-up order once after each reset. A single start pulse launches the order. The block offers one command at a time on a valid/ready command port. Each command carries a 3-bit command code, a 3-bit target bank, a flat byte address for the bank, and the mode payload bits that the command path places on the device: the DLL-reset flag and the 3-bit OCD calibration field. After the final dummy write is accepted, the block raises a sticky done flag and falls silent.

The geometry inputs give the column-count code, the row-count code, bank interleaving and the 16/32-bit bus choice. From these the block finds the address bit where the bank field starts, and it shifts each bank number to that position. The initial settle delay is counted in clock cycles as 200 times the cycles-per-microsecond input, which must be 1 or more. Geometry and the cycles-per-microsecond value are captured when the start pulse is accepted.

Top module: `ddr2_init_seq`

## Requirements
- R1: After reset and before a start pulse, cmd_valid_o and done_o are low.
- R2: Command codes are 0 normal mode, 1 NOP, 2 precharge all, 3 mode register set, 4 auto-refresh, 5 extended mode register set, 6 deep power-down, 7 LPDDR2 command.
- R3: The 15 commands appear in this order (code/bank): 1/0, 1/0, 2/0, 5/2, 5/3, 5/1, 3/0, 2/0, 4/0, 4/0, 3/0, 5/1, 5/1, 0/0, then the dummy write (code 0, bank 0).
- R4: After the first NOP is accepted, cmd_valid_o stays low for exactly 200 × cyc_per_us_i cycles, and then the second NOP is offered.
- R5: The bank offset is (column code + 9), plus (row code + 11) only when interleaving is off, plus 1 for a 16-bit bus or 2 for a 32-bit bus. cmd_addr_o equals cmd_bank_o shifted left by that offset.
- R6: dll_reset_o is 1 on the first mode register set and on the three commands after it. It is 0 on the second mode register set and on every other command.
- R7: ocd_o is 3'b111 on the first of the two late bank-1 extended mode register sets and 3'b000 on every other command, including the OCD-exit command.
- R8: An offered command and its payload hold steady until cmd_ready_i accepts it. Apart from the wait in R4, the next command is offered in the cycle after acceptance.
- R9: done_o rises in the cycle after the dummy write is accepted and stays high until reset, with no further commands.
- R10: A start pulse that arrives while the sequence is running or after it is done has no effect on the trace or on done_o.
- R11: cmd_write_o is 1 only on the dummy write, which follows the normal-mode command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| col_code_i | input | 2 | Column code, 0..3 for 9..12 columns |
| row_code_i | input | 2 | Row code, 0..3 for 11..14 rows |
| interleave_i | input | 1 | 1 = bank-interleaved address map |
| bus16_i | input | 1 | 1 = 16-bit data bus, 0 = 32-bit |
| cyc_per_us_i | input | CPU_W | Clock cycles per microsecond |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command accepted when high with valid |
| cmd_code_o | output | 3 | Command code |
| cmd_bank_o | output | 3 | Target bank |
| cmd_addr_o | output | ADDR_W | Bank number placed at the bank offset |
| cmd_write_o | output | 1 | Marks the dummy write |
| dll_reset_o | output | 1 | DLL-reset payload bit |
| ocd_o | output | 3 | OCD calibration payload field |
| done_o | output | 1 | Sequence complete (sticky) |

## Verification
If the step counter or a state register holds a wrong value, the next accepted command has the wrong code or bank. That error appears at the command port no later than the handshake that follows. A wrong offset register shows up in cmd_addr_o on the first extended mode register set, which is the fourth command. Errors in the flag registers show up as wrong dll_reset_o or ocd_o values on mode-set commands seven through thirteen. A timer fault lengthens or shortens the gap before the second NOP, so the bench measures that gap to the cycle. The bench checks every geometry combination against its own model of the offset formula.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [2:0] {
    CMD_NORMAL = 3'd0,
    CMD_NOP    = 3'd1,
    CMD_PALL   = 3'd2,
    CMD_MRS    = 3'd3,
    CMD_REF    = 3'd4,
    CMD_EMRS   = 3'd5,
    CMD_DPD    = 3'd6,
    CMD_LP2    = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } seq_state_e;

  localparam int NUM_STEPS    = 15;
  localparam int STEP_W       = $clog2(NUM_STEPS);
  localparam int STEP_DLL_ON  = 6;
  localparam int STEP_DLL_OFF = 10;
  localparam int STEP_OCD_DEF = 11;
  localparam int STEP_OCD_EXT = 12;
  localparam int STEP_LAST    = NUM_STEPS - 1;

endpackage

// File: rtl/ddr2_bank_offset.sv
module ddr2_bank_offset #(
  parameter int ADDR_W = 32,
  localparam int OFF_W = $clog2(ADDR_W)
) (
  input  logic [1:0]       col_code_i,
  input  logic [1:0]       row_code_i,
  input  logic             interleave_i,
  input  logic             bus16_i,
  output logic [OFF_W-1:0] offset_o
);

  logic [OFF_W-1:0] col_part, row_part, bus_part;

  always_comb begin
    col_part = OFF_W'(col_code_i) + OFF_W'(9);
    row_part = interleave_i ? '0 : (OFF_W'(row_code_i) + OFF_W'(11));
    bus_part = bus16_i ? OFF_W'(1) : OFF_W'(2);
    offset_o = col_part + row_part + bus_part;
  end

  // R5: a 2-bit bank number must fit above the offset
  always_comb begin
    offset_fit_chk: assert (int'(offset_o) <= ADDR_W - 2);
  end

endmodule

// File: rtl/ddr2_wait_timer.sv
module ddr2_wait_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q <= CNT_W'(1));

endmodule

// File: rtl/ddr2_step_rom.sv
module ddr2_step_rom
  import ddr2_init_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  output cmd_e              code_o,
  output logic [2:0]        bank_o,
  output logic              write_o
);

  always_comb begin
    bank_o  = 3'd0;
    write_o = 1'b0;
    unique case (step_i)
      4'd0, 4'd1: code_o = CMD_NOP;
      4'd2, 4'd7: code_o = CMD_PALL;
      4'd3:       begin code_o = CMD_EMRS; bank_o = 3'd2; end
      4'd4:       begin code_o = CMD_EMRS; bank_o = 3'd3; end
      4'd5, 4'd11, 4'd12: begin code_o = CMD_EMRS; bank_o = 3'd1; end
      4'd6, 4'd10: code_o = CMD_MRS;
      4'd8, 4'd9:  code_o = CMD_REF;
      4'd13:       code_o = CMD_NORMAL;
      4'd14:       begin code_o = CMD_NORMAL; write_o = 1'b1; end
      default:     code_o = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CPU_W   = 8,
  parameter int WAIT_US = 200,
  localparam int OFF_W  = $clog2(ADDR_W),
  localparam int WAIT_W = CPU_W + $clog2(WAIT_US + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        col_code_i,
  input  logic [1:0]        row_code_i,
  input  logic              interleave_i,
  input  logic              bus16_i,
  input  logic [CPU_W-1:0]  cyc_per_us_i,
  output logic              cmd_valid_o,
  input  logic              cmd_ready_i,
  output logic [2:0]        cmd_code_o,
  output logic [2:0]        cmd_bank_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic              cmd_write_o,
  output logic              dll_reset_o,
  output logic [2:0]        ocd_o,
  output logic              done_o
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [OFF_W-1:0]  off_q, off_calc;
  logic [CPU_W-1:0]  cpu_q;
  logic              dll_q, dll_d;
  logic [2:0]        ocd_q, ocd_d;
  logic              done_q, done_d;
  logic              capture, tmr_load, tmr_expire, accept;
  logic [WAIT_W-1:0] wait_cycles;
  cmd_e              rom_code;
  logic [2:0]        rom_bank;
  logic              rom_write;

  ddr2_bank_offset #(.ADDR_W(ADDR_W)) u_offset (
    .col_code_i   (col_code_i),
    .row_code_i   (row_code_i),
    .interleave_i (interleave_i),
    .bus16_i      (bus16_i),
    .offset_o     (off_calc)
  );

  ddr2_step_rom u_rom (
    .step_i  (step_q),
    .code_o  (rom_code),
    .bank_o  (rom_bank),
    .write_o (rom_write)
  );

  assign wait_cycles = WAIT_W'(cpu_q) * WAIT_W'(WAIT_US);

  ddr2_wait_timer #(.CNT_W(WAIT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (wait_cycles),
    .expire_o   (tmr_expire)
  );

  assign accept = (state_q == ST_ISSUE) && cmd_ready_i;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    dll_d    = dll_q;
    ocd_d    = ocd_q;
    done_d   = done_q;
    capture  = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_ISSUE;
          step_d  = '0;
          dll_d   = 1'b0;
          ocd_d   = 3'b000;
          capture = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (accept) begin
          if (step_q == STEP_W'(0)) begin
            state_d  = ST_WAIT;
            step_d   = STEP_W'(1);
            tmr_load = 1'b1;
          end else if (step_q == STEP_W'(STEP_LAST)) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end else begin
            step_d = step_q + STEP_W'(1);
            if (step_d == STEP_W'(STEP_DLL_ON))  dll_d = 1'b1;
            if (step_d == STEP_W'(STEP_DLL_OFF)) dll_d = 1'b0;
            if (step_d == STEP_W'(STEP_OCD_DEF)) ocd_d = 3'b111;
            if (step_d == STEP_W'(STEP_OCD_EXT)) ocd_d = 3'b000;
          end
        end
      end
      ST_WAIT: begin
        if (tmr_expire) state_d = ST_ISSUE;
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      dll_q   <= 1'b0;
      ocd_q   <= 3'b000;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      dll_q   <= dll_d;
      ocd_q   <= ocd_d;
      done_q  <= done_d;
    end
  end

  // configuration captured on start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q <= '0;
      cpu_q <= '0;
    end else if (capture) begin
      off_q <= off_calc;
      cpu_q <= cyc_per_us_i;
    end
  end

  assign cmd_valid_o = (state_q == ST_ISSUE);
  assign cmd_code_o  = rom_code;
  assign cmd_bank_o  = rom_bank;
  assign cmd_addr_o  = ADDR_W'(rom_bank) << off_q;
  assign cmd_write_o = rom_write && cmd_valid_o;
  assign dll_reset_o = dll_q;
  assign ocd_o       = ocd_q;
  assign done_o      = done_q;

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_code_o) &&
      $stable(cmd_bank_o) && $stable(cmd_addr_o) && $stable(dll_reset_o) && $stable(ocd_o)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (done_o && !cmd_valid_o));

  // R9
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(cmd_valid_o && cmd_ready_i && cmd_write_o));

  // R6
  dll_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_code_o == CMD_EMRS) |-> !dll_reset_o);

  // R7
  ocd_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ocd_o != 3'b000) |-> (cmd_valid_o && cmd_code_o == CMD_EMRS && cmd_bank_o == 3'd1));

endmodule

// File: tb/tb_ddr2_init_seq.sv
`timescale 1ns/1ps
module tb_ddr2_init_seq;

  localparam int ADDR_W = 32;
  localparam int CPU_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start_i = 1'b0;
  logic [1:0]        col_code_i = '0, row_code_i = '0;
  logic              interleave_i = 1'b0, bus16_i = 1'b0;
  logic [CPU_W-1:0]  cyc_per_us_i = 8'd1;
  logic              cmd_valid_o, cmd_ready_i = 1'b0;
  logic [2:0]        cmd_code_o, cmd_bank_o, ocd_o;
  logic [ADDR_W-1:0] cmd_addr_o;
  logic              cmd_write_o, dll_reset_o, done_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  ddr2_init_seq #(.ADDR_W(ADDR_W), .CPU_W(CPU_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .col_code_i(col_code_i), .row_code_i(row_code_i),
    .interleave_i(interleave_i), .bus16_i(bus16_i),
    .cyc_per_us_i(cyc_per_us_i),
    .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
    .cmd_code_o(cmd_code_o), .cmd_bank_o(cmd_bank_o), .cmd_addr_o(cmd_addr_o),
    .cmd_write_o(cmd_write_o), .dll_reset_o(dll_reset_o), .ocd_o(ocd_o),
    .done_o(done_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic report_and_end();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report_and_end();
  end

  // expected trace from R3, R6, R7, R11
  function automatic int exp_code(int s);
    case (s)
      0, 1: return 1;
      2, 7: return 2;
      3, 4, 5, 11, 12: return 5;
      6, 10: return 3;
      8, 9: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_bank(int s);
    case (s)
      3: return 2;
      4: return 3;
      5, 11, 12: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_off(int col, int row, bit il, bit b16);
    int o = col + 9;
    if (!il) o += row + 11;
    o += b16 ? 1 : 2;
    return o;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_ready_i = 1'b0;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic test_reset_state();
    do_reset();
    repeat (5) begin
      @(negedge clk);
      check(!cmd_valid_o, "R1", "valid idle", cmd_valid_o, 0);
      check(!done_o, "R1", "done idle", done_o, 0);
    end
  endtask

  task automatic run_seq(input int col, input int row, input bit il, input bit b16,
                         input int cpu, input int stall, input bit poke);
    int off;
    do_reset();
    col_code_i = 2'(col); row_code_i = 2'(row);
    interleave_i = il; bus16_i = b16; cyc_per_us_i = CPU_W'(cpu);
    off = exp_off(col, row, il, b16);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int s = 0; s < 15; s++) begin
      int gap = 0;
      while (!cmd_valid_o && gap < 100000) begin
        if (poke && gap == 5) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        gap++;
        check(!done_o, "R9", "done early", done_o, 0);
      end
      if (s == 1) check(gap == 200 * cpu, "R4", "wait gap", gap, 200 * cpu);
      else        check(gap == 0, "R8", "step gap", gap, 0);
      check(int'(cmd_code_o) == exp_code(s), "R3", $sformatf("code step %0d", s),
            cmd_code_o, exp_code(s));
      check(int'(cmd_bank_o) == exp_bank(s), "R3", $sformatf("bank step %0d", s),
            cmd_bank_o, exp_bank(s));
      check(cmd_addr_o == (ADDR_W'(exp_bank(s)) << off), "R5",
            $sformatf("addr step %0d", s), cmd_addr_o, ADDR_W'(exp_bank(s)) << off);
      check(dll_reset_o == (s >= 6 && s <= 9), "R6", $sformatf("dll step %0d", s),
            dll_reset_o, (s >= 6 && s <= 9));
      check(int'(ocd_o) == ((s == 11) ? 7 : 0), "R7", $sformatf("ocd step %0d", s),
            ocd_o, (s == 11) ? 7 : 0);
      check(cmd_write_o == (s == 14), "R11", $sformatf("write step %0d", s),
            cmd_write_o, (s == 14));
      if (s == 0 || s == 14)
        check(cmd_code_o == 3'd0 || s == 0, "R2", "normal code", cmd_code_o, 0);
      for (int k = 0; k < stall; k++) begin
        logic [2:0] c0 = cmd_code_o;
        logic [ADDR_W-1:0] a0 = cmd_addr_o;
        if (poke) start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(cmd_valid_o && cmd_code_o == c0 && cmd_addr_o == a0, "R8",
              "hold under stall", cmd_addr_o, a0);
      end
      cmd_ready_i = 1'b1;
      @(negedge clk);
      cmd_ready_i = 1'b0;
    end
    check(done_o, "R9", "done after write", done_o, 1);
  endtask

  task automatic test_after_done();
    run_seq(2, 1, 1'b0, 1'b1, 1, 0, 1'b0);
    for (int k = 0; k < 20; k++) begin
      start_i = (k == 3);
      @(negedge clk);
      start_i = 1'b0;
      check(done_o, "R9", "done sticky", done_o, 1);
      check(!cmd_valid_o, "R10", "no restart after done", cmd_valid_o, 0);
    end
  endtask

  task automatic test_geometry_sweep();
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        for (int i = 0; i < 2; i++)
          for (int b = 0; b < 2; b++)
            run_seq(c, r, bit'(i), bit'(b), 1, 0, 1'b0);
  endtask

  task automatic test_stall_and_poke();
    run_seq(3, 3, 1'b0, 1'b0, 3, 2, 1'b1);   // R10 start pokes while busy
    run_seq(0, 2, 1'b1, 1'b1, 2, 1, 1'b0);
  endtask

  initial begin
    test_reset_state();
    test_geometry_sweep();
    test_stall_and_poke();
    test_after_done();
    report_and_end();
  end

endmodule